// File: doc/BRIEF.md
# Boost Bias Regulator Mode Controller

This block sequences a small auxiliary boost converter that keeps a controller's own supply rail alive. It takes seven comparator flags in raw, unsynchronised form: four about the regulator's input rail, two about the supply rail it boosts, and one from the switch current sense. From these it drives the gate of the boost switch and reports which of five operating modes it is in. It works on its own clock. All thresholds live in the analog comparators in front of it.

Switching has three reasons to run or stop. A supply below its survival level forces back-to-back switching whatever the input rail looks like. An input rail above its turn-on level enables cycle-by-cycle regulation: a new pulse starts only while the supply is below its target. An input rail high enough to feed the supply directly parks the block in bypass until the input falls back through a lower threshold. Each pulse is bounded by a blanked peak-current trip, a maximum on-time and a minimum period. The input undervoltage flag is looked at only inside the blanking window. If it is seen there, the block latches a fault that needs a fresh turn-on edge or a survival event to clear.

Top module: `boost_bias_ctrl`

## Requirements
- R1: After reset, `gate_o` is 0 and `mode_o` is 0 (disabled). The mode codes are: 0 disabled, 1 survival, 2 regulating, 3 bypass, 4 UVLO fault.
- R2: While `sup_surv_raw` is low and the block is in mode 0 (input turn-on flag low), `gate_o` stays low. The gate is high only in modes 1 and 2.
- R3: While `sup_surv_raw` is high, the mode is 1 whatever `in_on_raw` and `in_uv_raw` say. Pulses then repeat every TPER_MIN cycles without waiting for `sup_reg_lo_raw`, and the UV flag is ignored.
- R4: In mode 2, a pulse starts only while `sup_reg_lo_raw` is high. While it is low, the gate stays low and the mode stays 2.
- R5: Outside blanking, a high `ipk_raw` turns the gate off. A trip raised d cycles after the gate rose gives a high time of min(max(d+3, BLANK_CYC+1), TON_MAX) cycles.
- R6: `ipk_raw` has no effect during the first BLANK_CYC cycles of a pulse.
- R7: With no trip, a pulse is high for exactly TON_MAX cycles.
- R8: Rising edges of `gate_o` are at least TPER_MIN cycles apart, and exactly TPER_MIN apart when the start condition is already met.
- R9: In mode 2, a high `in_uv_raw` seen during blanking drops the gate and sets mode 4 on the same edge. A UV flag raised at cycle d of a pulse faults only when d+2 < BLANK_CYC; otherwise the pulse runs on.
- R10: Mode 4 holds with the gate low until `in_on_raw` goes low and then high again. On that, the mode goes 4→0→2 on successive edges. A survival event also ends mode 4.
- R11: In mode 2, a high `in_dis_hi_raw` sets mode 3 with the gate low. Mode 3 holds until `in_en_lo_raw` goes high, and then goes to mode 2.
- R12: Every raw flag passes through SYNC_STAGES flops. With the default of 2, a flag change first shows at the outputs on the third rising edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_on_raw | input | 1 | Input rail above turn-on level |
| in_uv_raw | input | 1 | Input rail below UVLO-off level |
| in_en_lo_raw | input | 1 | Input rail below boost re-enable level |
| in_dis_hi_raw | input | 1 | Input rail at or above boost disable level |
| sup_surv_raw | input | 1 | Supply rail below survival level |
| sup_reg_lo_raw | input | 1 | Supply rail below regulation target |
| ipk_raw | input | 1 | Switch current at peak limit |
| gate_o | output | 1 | Registered boost switch gate |
| mode_o | output | 3 | Operating mode code |

## Verification
Every mode and gate result is due on the third rising edge after the raw flag changes: two synchroniser flops, then the register that holds the mode and the gate. The bench drives and samples 1 ns after each edge and counts edges to the expected result. It checks the mode one sample before and at that edge. Pulse widths and periods are counted in samples from the sample in which the gate first reads high. Trip and UV delays are swept against the closed-form formulas in R5 and R9, so the blanking edge is hit from both sides.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

  typedef enum logic [2:0] {
    MODE_DIS   = 3'd0,
    MODE_SURV  = 3'd1,
    MODE_REG   = 3'd2,
    MODE_BYP   = 3'd3,
    MODE_FAULT = 3'd4
  } bbc_mode_e;

  typedef struct packed {
    logic in_on;
    logic in_uv;
    logic in_en_lo;
    logic in_dis_hi;
    logic sup_surv;
    logic sup_reg_lo;
    logic ipk;
  } bbc_flags_t;

  // pulse is still inside its blanking window
  function automatic logic in_blank(input int unsigned cnt, input int unsigned blank_cyc);
    return cnt < blank_cyc;
  endfunction

  // on-time counter has reached its last allowed cycle
  function automatic logic ton_done(input int unsigned cnt, input int unsigned ton_max);
    return cnt >= ton_max - 1;
  endfunction

  // minimum period has elapsed since the last rising gate
  function automatic logic per_done(input int unsigned cnt, input int unsigned tper_min);
    return cnt >= tper_min - 1;
  endfunction

  function automatic logic may_switch(input bbc_mode_e m);
    return (m == MODE_SURV) || (m == MODE_REG);
  endfunction

endpackage

// File: rtl/bbc_sync.sv
module bbc_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/bbc_mode_fsm.sv
module bbc_mode_fsm
  import bbc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      s_on,
  input  logic      s_uv,
  input  logic      s_en_lo,
  input  logic      s_dis_hi,
  input  logic      s_surv,
  input  logic      gate,
  input  logic      blank,
  output bbc_mode_e mode,
  output bbc_mode_e mode_nxt,
  output logic      uv_hit
);

  logic rearm;

  // undervoltage is only sampled while the switch is on and blanked
  assign uv_hit = (mode == MODE_REG) && gate && blank && s_uv;

  always_comb begin
    mode_nxt = mode;
    if (s_surv) begin
      mode_nxt = MODE_SURV;
    end else begin
      unique case (mode)
        MODE_SURV:  mode_nxt = MODE_DIS;
        MODE_DIS:   if (s_on) mode_nxt = MODE_REG;
        MODE_REG: begin
          if (uv_hit)        mode_nxt = MODE_FAULT;
          else if (s_dis_hi) mode_nxt = MODE_BYP;
          else if (!s_on)    mode_nxt = MODE_DIS;
        end
        MODE_BYP:   if (s_en_lo) mode_nxt = MODE_REG;
        MODE_FAULT: if (rearm && s_on) mode_nxt = MODE_DIS;
        default:    mode_nxt = MODE_DIS;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= MODE_DIS;
      rearm <= 1'b0;
    end else begin
      mode <= mode_nxt;
      if (mode != MODE_FAULT)  rearm <= 1'b0;
      else if (!s_on)          rearm <= 1'b1;
    end
  end

endmodule

// File: rtl/bbc_pulse_timer.sv
module bbc_pulse_timer
  import bbc_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int BLANK_CYC = 48,
  parameter int TON_MAX   = 200,
  parameter int TPER_MIN  = 250
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bbc_mode_e        mode_nxt,
  input  logic             reg_lo,
  input  logic             ipk,
  output logic             gate,
  output logic [CNT_W-1:0] on_cnt,
  output logic             blank
);

  localparam logic [CNT_W-1:0] PER_LAST = CNT_W'(TPER_MIN - 1);

  logic [CNT_W-1:0] per_cnt;
  logic allow_n, start_evt, stop_evt, gate_nxt, rise_nxt, per_ok, on_last;

  assign blank   = in_blank(32'(on_cnt), BLANK_CYC);
  assign per_ok  = per_done(32'(per_cnt), TPER_MIN);
  assign on_last = ton_done(32'(on_cnt), TON_MAX);
  assign allow_n = may_switch(mode_nxt);

  // survival runs back to back; regulation waits for the supply flag
  assign start_evt = !gate && allow_n && per_ok && ((mode_nxt == MODE_SURV) || reg_lo);
  assign stop_evt  = gate && ((!blank && ipk) || on_last);
  assign gate_nxt  = allow_n && (gate ? !stop_evt : start_evt);
  assign rise_nxt  = !gate && gate_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate    <= 1'b0;
      on_cnt  <= '0;
      per_cnt <= PER_LAST;
    end else begin
      gate <= gate_nxt;
      if (rise_nxt)              on_cnt <= '0;
      else if (gate && !on_last) on_cnt <= on_cnt + 1'b1;
      if (rise_nxt)              per_cnt <= '0;
      else if (!per_ok)          per_cnt <= per_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/boost_bias_ctrl.sv
module boost_bias_ctrl
  import bbc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8,
  parameter int BLANK_CYC   = 48,
  parameter int TON_MAX     = 200,
  parameter int TPER_MIN    = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_on_raw,
  input  logic       in_uv_raw,
  input  logic       in_en_lo_raw,
  input  logic       in_dis_hi_raw,
  input  logic       sup_surv_raw,
  input  logic       sup_reg_lo_raw,
  input  logic       ipk_raw,
  output logic       gate_o,
  output logic [2:0] mode_o
);

  localparam int NFLAG = $bits(bbc_flags_t);

  generate
    if (TPER_MIN <= TON_MAX || TPER_MIN > (1 << CNT_W) || BLANK_CYC >= TON_MAX) begin : g_bad_cfg
      $error("boost_bias_ctrl: inconsistent timing parameters");
    end
  endgenerate

  bbc_flags_t raw_f, s_f;
  logic s_on, s_uv, s_en_lo, s_dis_hi, s_surv, s_reg_lo, s_ipk;
  logic gate, blank, uv_hit;
  logic [CNT_W-1:0] on_cnt;
  bbc_mode_e mode, mode_nxt;

  assign raw_f = '{in_on: in_on_raw, in_uv: in_uv_raw, in_en_lo: in_en_lo_raw,
                   in_dis_hi: in_dis_hi_raw, sup_surv: sup_surv_raw,
                   sup_reg_lo: sup_reg_lo_raw, ipk: ipk_raw};

  bbc_sync #(.W(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_f), .q(s_f)
  );

  assign s_on     = s_f.in_on;
  assign s_uv     = s_f.in_uv;
  assign s_en_lo  = s_f.in_en_lo;
  assign s_dis_hi = s_f.in_dis_hi;
  assign s_surv   = s_f.sup_surv;
  assign s_reg_lo = s_f.sup_reg_lo;
  assign s_ipk    = s_f.ipk;

  bbc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .s_on(s_on), .s_uv(s_uv), .s_en_lo(s_en_lo), .s_dis_hi(s_dis_hi), .s_surv(s_surv),
    .gate(gate), .blank(blank),
    .mode(mode), .mode_nxt(mode_nxt), .uv_hit(uv_hit)
  );

  bbc_pulse_timer #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC), .TON_MAX(TON_MAX), .TPER_MIN(TPER_MIN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .mode_nxt(mode_nxt), .reg_lo(s_reg_lo), .ipk(s_ipk),
    .gate(gate), .on_cnt(on_cnt), .blank(blank)
  );

  assign gate_o = gate;
  assign mode_o = mode;

endmodule

// File: rtl/bbc_checker.sv
module bbc_checker #(
  parameter int CNT_W    = 8,
  parameter int TON_MAX  = 200,
  parameter int TPER_MIN = 250
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate,
  input logic [2:0]       mode,
  input logic             s_on,
  input logic             s_uv,
  input logic             s_en_lo,
  input logic             s_surv,
  input logic             s_ipk,
  input logic [CNT_W-1:0] on_cnt,
  input logic             blank,
  input logic             uv_hit
);

  localparam logic [2:0] M_SURV = 3'd1, M_REG = 3'd2, M_BYP = 3'd3, M_FAULT = 3'd4;

  logic [15:0] since;
  logic gate_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since  <= 16'(TPER_MIN);
      gate_d <= 1'b0;
    end else begin
      gate_d <= gate;
      p_mode_legal_r1: assert (mode <= 3'd4) else $error("illegal mode code %0d", mode);
      if (gate && !gate_d) begin
        p_min_period_r8: assert (since >= 16'(TPER_MIN - 1)) else $error("gate period too short");
        since <= '0;
      end else if (since < 16'(TPER_MIN)) begin
        since <= since + 1'b1;
      end
    end
  end

  p_gate_in_switch_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> (mode == M_SURV || mode == M_REG));

  p_surv_override_r3: assert property (@(posedge clk) disable iff (!rst_n)
    s_surv |=> mode == M_SURV);

  p_trip_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gate && !blank && s_ipk |=> !gate);

  p_ontime_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    gate && on_cnt == CNT_W'(TON_MAX - 1) |=> !gate);

  p_uv_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_REG && gate && blank && s_uv && !s_surv |=> mode == M_FAULT && !gate);

  p_uv_sampled_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uv_hit |-> blank && gate);

  p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_FAULT && !s_surv && !s_on |=> mode == M_FAULT);

  p_bypass_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_BYP && !s_en_lo && !s_surv |=> mode == M_BYP);

endmodule

bind boost_bias_ctrl bbc_checker #(.CNT_W(CNT_W), .TON_MAX(TON_MAX), .TPER_MIN(TPER_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .mode(mode_o), .s_on(s_on), .s_uv(s_uv),
  .s_en_lo(s_en_lo), .s_surv(s_surv), .s_ipk(s_ipk), .on_cnt(on_cnt), .blank(blank),
  .uv_hit(uv_hit)
);

// File: tb/sim_boost_bias_ctrl.sv
`timescale 1ns/1ps
module sim_boost_bias_ctrl;

  localparam int BLANK = 3, TON = 8, TPER = 12, LAT = 3;
  localparam int M_DIS = 0, M_SURV = 1, M_REG = 2, M_BYP = 3, M_FAULT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_on = 0, in_uv = 0, in_en_lo = 0, in_dis_hi = 0, sup_surv = 0, sup_reg_lo = 0, ipk = 0;
  logic gate;
  logic [2:0] mode;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  boost_bias_ctrl #(.SYNC_STAGES(2), .CNT_W(5), .BLANK_CYC(BLANK), .TON_MAX(TON), .TPER_MIN(TPER)) u0 (
    .clk(clk), .rst_n(rst_n), .in_on_raw(in_on), .in_uv_raw(in_uv), .in_en_lo_raw(in_en_lo),
    .in_dis_hi_raw(in_dis_hi), .sup_surv_raw(sup_surv), .sup_reg_lo_raw(sup_reg_lo),
    .ipk_raw(ipk), .gate_o(gate), .mode_o(mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_rise(input string req);
    logic prev;
    bit ok;
    prev = gate;
    ok = 0;
    for (int i = 0; i < 200 && !ok; i++) begin
      tick(1);
      if (gate && !prev) ok = 1;
      prev = gate;
    end
    chk(ok, req, 0, 1);
  endtask

  // high time of the pulse that just rose; flag sel (0 ipk, 1 uv) raised at cycle d (-1 none)
  task automatic pulse_len(input int d, input int sel, output int len);
    len = 0;
    for (int k = 0; k < 100; k++) begin
      if (k == d) begin
        if (sel == 0) ipk = 1; else in_uv = 1;
      end
      if (!gate) break;
      len++;
      tick(1);
    end
    ipk = 0;
    in_uv = 0;
  endtask

  task automatic period_len(output int p);
    logic prev;
    p = 0;
    prev = gate;
    for (int i = 0; i < 100; i++) begin
      tick(1);
      p++;
      if (gate && !prev) break;
      prev = gate;
    end
  endtask

  task automatic quiet(input int n, input int exp_mode, input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < n; i++) begin
      if (gate || mode != 3'(exp_mode)) bad++;
      tick(1);
    end
    chk(bad == 0, req, bad, 0);
  endtask

  function automatic int trip_exp(input int d);
    int v;
    v = (d + LAT > BLANK + 1) ? d + LAT : BLANK + 1;
    return (v < TON) ? v : TON;
  endfunction

  initial begin
    int len, p;
    tick(3);
    rst_n = 1;
    tick(1);
    chk(gate == 0 && mode == 3'(M_DIS), "R1 reset state", mode, M_DIS);
    quiet(30, M_DIS, "R2 idle while input below turn-on");

    // R12: three edges from raw flag to outputs
    in_on = 1; sup_reg_lo = 1; in_en_lo = 1;
    tick(2);
    chk(mode == 3'(M_DIS) && gate == 0, "R12 no change after two edges", mode, M_DIS);
    tick(1);
    chk(mode == 3'(M_REG), "R12 regulating on third edge", mode, M_REG);
    chk(gate == 1, "R4 pulse starts with supply low", gate, 1);
    pulse_len(-1, 0, len);
    chk(len == TON, "R7 untripped on-time", len, TON);
    wait_rise("R8 rise");
    period_len(p);
    chk(p == TPER, "R8 minimum period", p, TPER);

    // R5/R6: trip delay sweep across the blanking edge
    for (int d = 0; d <= 7; d++) begin
      wait_rise("R5 rise");
      pulse_len(d, 0, len);
      chk(len == trip_exp(d), (d + LAT <= BLANK) ? "R6 trip blanked" : "R5 trip length", len, trip_exp(d));
    end

    // R4: no pulse while supply at target
    sup_reg_lo = 0;
    tick(20);
    quiet(40, M_REG, "R4 no pulse while supply at target");
    sup_reg_lo = 1;
    tick(2);
    chk(gate == 0, "R4 still low two edges after request", gate, 0);
    tick(1);
    chk(gate == 1, "R4 pulse on third edge after request", gate, 1);

    // R9: UV outside blanking ignored, inside faults
    for (int d = 2; d >= 0; d--) begin
      int exp_len;
      bit flt;
      flt = (d + 2 < BLANK);
      exp_len = flt ? d + LAT : TON;
      wait_rise("R9 rise");
      pulse_len(d, 1, len);
      chk(len == exp_len, "R9 uv pulse length", len, exp_len);
      chk(mode == 3'(flt ? M_FAULT : M_REG), "R9 mode after uv", mode, flt ? M_FAULT : M_REG);
    end

    // R10: fault holds, re-arm on turn-on edge
    quiet(30, M_FAULT, "R10 fault holds with turn-on high");
    in_on = 0;
    tick(6);
    chk(mode == 3'(M_FAULT), "R10 fault holds while turn-on low", mode, M_FAULT);
    in_on = 1;
    tick(3);
    chk(mode == 3'(M_DIS), "R10 release to disabled", mode, M_DIS);
    tick(1);
    chk(mode == 3'(M_REG), "R10 then regulating", mode, M_REG);

    // R3/R10: survival clears a fault and runs continuous cycles
    wait_rise("R10 rise");
    pulse_len(0, 1, len);
    chk(mode == 3'(M_FAULT), "R10 second fault", mode, M_FAULT);
    sup_surv = 1; in_on = 0; sup_reg_lo = 0;
    tick(3);
    chk(mode == 3'(M_SURV), "R3 R10 survival overrides fault", mode, M_SURV);
    wait_rise("R3 rise");
    in_uv = 1;
    len = 0;
    for (int k = 0; k < 50 && gate; k++) begin len++; tick(1); end
    chk(len == TON, "R3 uv ignored in survival", len, TON);
    wait_rise("R3 rise");
    period_len(p);
    chk(p == TPER, "R3 back-to-back period", p, TPER);
    in_uv = 0;
    sup_surv = 0;
    tick(8);
    chk(mode == 3'(M_DIS), "R2 back to disabled", mode, M_DIS);
    quiet(20, M_DIS, "R2 idle after survival");

    // R11: bypass band
    in_on = 1; sup_reg_lo = 1; in_en_lo = 1;
    tick(5);
    chk(mode == 3'(M_REG), "R11 regulating before bypass", mode, M_REG);
    in_dis_hi = 1; in_en_lo = 0;
    tick(3);
    chk(mode == 3'(M_BYP) && gate == 0, "R11 bypass entered", mode, M_BYP);
    in_dis_hi = 0;
    quiet(20, M_BYP, "R11 bypass holds inside band");
    in_en_lo = 1;
    tick(2);
    chk(mode == 3'(M_BYP), "R11 bypass two edges after enable", mode, M_BYP);
    tick(1);
    chk(mode == 3'(M_REG), "R11 regulating after enable", mode, M_REG);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule